// File: doc/BRIEF.md
# Float/Integer Conversion Unit

This block is the conversion stage of a vector ALU. It turns IEEE-754 single-precision values into 32-bit signed or unsigned integers, and 32-bit signed or unsigned integers into single-precision values. Each request carries a four-lane operand and three control bits: conversion direction, signedness and lane mode.

In four-wide mode every lane is converted from its own input. In broadcast mode only lane 0 counts, and its result is copied to all four output lanes. Float-to-integer conversion truncates toward zero and saturates at the limits of the target type. A NaN does not convert to zero: it gives a saturated value whose direction follows the NaN's sign bit. Integer-to-float conversion rounds to nearest, with ties to even.

Requests enter through a valid/ready handshake. Results leave through a two-stage pipeline with an aligned valid flag. The unit accepts one request per cycle.

Top module: `cvt_unit`

## Requirements
- R1: With in_f2i=1 and in_signed=1, a non-NaN input is truncated toward zero. Values above 0x7FFFFFFF, including +infinity, give 0x7FFFFFFF. Values below -2^31, including -infinity, give 0x80000000.
- R2: With in_f2i=1 and in_signed=0, every negative non-NaN input gives 0x00000000. Positive values are truncated toward zero, and values of 2^32 or more, including +infinity, give 0xFFFFFFFF.
- R3: A lane is a NaN when its bits 30:0 exceed 0x7F800000. With in_f2i=1 and in_signed=1, a NaN with bit 31 set gives 0x80000000 and a NaN with bit 31 clear gives 0x7FFFFFFF.
- R4: With in_f2i=1 and in_signed=0, a NaN with bit 31 set gives 0x00000000 and a NaN with bit 31 clear gives 0xFFFFFFFF.
- R5: With in_f2i=0 and in_signed=1, the lane is read as a two's-complement integer and converted to single precision. Rounding is to nearest with ties to even, and an input of 0 gives 0x00000000.
- R6: With in_f2i=0 and in_signed=0, the lane is read as an unsigned integer and converted with the same rounding as R5.
- R7: With in_bcast=1, all four output lanes carry the result of converting lane 0 (in_data[31:0]). The contents of lanes 1 to 3 have no effect.
- R8: With in_bcast=0, output lane i (bits 32i+31:32i) is the conversion of input lane i, for every lane.
- R9: While rst_n is low, in_ready and out_valid are 0, and no request presented during reset produces an output. A request is taken only on a rising edge where in_valid and in_ready are both 1. in_ready is 1 from the first edge after reset onward.
- R10: A request taken on edge k appears on out_data, with out_valid=1, during the cycle after edge k+1. Every accepted request produces exactly one result, in order, and out_valid is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_f2i | input | 1 | 1: float to integer, 0: integer to float |
| in_signed | input | 1 | 1: signed integer side, 0: unsigned |
| in_bcast | input | 1 | 1: convert lane 0 and copy it to all lanes; 0: four-wide |
| in_data | input | 128 | Operand, lane i in bits 32i+31:32i |
| out_valid | output | 1 | Result present |
| out_data | output | 128 | Result, lane i in bits 32i+31:32i |

## Verification
The bench drives NaNs of both signs, infinities, values just inside and just outside each integer range, fractions below one, and exact -2^31. A unit that mapped NaN to zero, or that ignored the NaN's sign, would give wrong saturated words. A unit that wrapped instead of clamping would give small or sign-flipped integers. For integer to float, the bench uses halfway cases with both odd and even mantissas, all-ones values that round up to the next power of two, and zero. Truncating or always rounding up would show there as an error of one ulp or an exponent that never increments. Broadcast requests fill lanes 1 to 3 with values that would convert differently, and requests are issued back to back, so lane mix-ups, dropped or duplicated results, and latency errors all show up in the scoreboard.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    parameter int unsigned LANES = 4;
    parameter int unsigned WORD  = 32;

    localparam logic [7:0] EXP_BIAS = 8'd127;
    localparam logic [7:0] EXP_TOP  = 8'd158;   // bias + 31
    localparam logic [7:0] EXP_OVF  = 8'd159;   // first exponent beyond 32-bit range

    typedef struct packed {
        logic f2i;
        logic sgn;
        logic bcast;
    } cvt_ctl_t;

    function automatic logic [5:0] lead_zeros(input logic [31:0] v);
        logic [5:0] n;
        logic       hit;
        n   = 6'd0;
        hit = 1'b0;
        for (int b = 31; b >= 0; b--) begin
            if (!hit && v[b]) begin
                hit = 1'b1;
            end else if (!hit) begin
                n = n + 6'd1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/cvt_f2i_lane.sv
module cvt_f2i_lane
    import cvt_pkg::*;
(
    input  logic [31:0] a,
    input  logic        sgn,
    output logic [31:0] y
);
    logic        neg;
    logic [7:0]  expo;
    logic [22:0] frac;
    logic        is_nan;
    logic        tiny;
    logic        huge;
    logic [7:0]  sh;
    logic [63:0] wide;
    logic [31:0] mag;

    always_comb begin
        neg    = a[31];
        expo   = a[30:23];
        frac   = a[22:0];
        is_nan = (a[30:0] > 31'h7F80_0000);
        tiny   = (expo < EXP_BIAS);
        huge   = (expo >= EXP_OVF);
        sh     = expo - EXP_BIAS;
        wide   = {40'd0, 1'b1, frac} << sh;
        mag    = 32'(wide >> 23);

        if (is_nan) begin
            if (sgn) y = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else     y = neg ? 32'h0000_0000 : 32'hFFFF_FFFF;
        end else if (tiny) begin
            y = 32'd0;
        end else if (sgn) begin
            if (neg) y = (huge || mag > 32'h8000_0000) ? 32'h8000_0000 : (~mag + 32'd1);
            else     y = (huge || mag[31]) ? 32'h7FFF_FFFF : mag;
        end else begin
            if (neg)       y = 32'd0;
            else if (huge) y = 32'hFFFF_FFFF;
            else           y = mag;
        end
    end
endmodule

// File: rtl/cvt_i2f_lane.sv
module cvt_i2f_lane
    import cvt_pkg::*;
(
    input  logic [31:0] a,
    input  logic        sgn,
    output logic [31:0] y
);
    logic        neg;
    logic [31:0] mag;
    logic [5:0]  lz;
    logic [31:0] fr;
    logic [7:0]  expo;
    logic        grd;
    logic        stk;
    logic        up;
    logic [30:0] body;

    always_comb begin
        neg  = sgn & a[31];
        mag  = neg ? (~a + 32'd1) : a;
        lz   = lead_zeros(mag);
        fr   = (mag << lz) << 1;          // hidden bit dropped
        expo = EXP_TOP - {2'b00, lz};
        grd  = fr[8];
        stk  = |fr[7:0];
        up   = grd & (stk | fr[9]);
        // carry out of the mantissa bumps the exponent
        body = {expo, fr[31:9]} + {30'd0, up};
        y    = (mag == 32'd0) ? 32'd0 : {neg, body};
    end
endmodule

// File: rtl/cvt_lane.sv
module cvt_lane (
    input  logic [31:0] a,
    input  logic        to_int,
    input  logic        sgn,
    output logic [31:0] y
);
    logic [31:0] y_int;
    logic [31:0] y_flt;

    cvt_f2i_lane u_f2i (.a(a), .sgn(sgn), .y(y_int));
    cvt_i2f_lane u_i2f (.a(a), .sgn(sgn), .y(y_flt));

    always_comb y = to_int ? y_int : y_flt;
endmodule

// File: rtl/cvt_unit.sv
module cvt_unit
    import cvt_pkg::*;
#(
    parameter int unsigned LANES = cvt_pkg::LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_f2i,
    input  logic                    in_signed,
    input  logic                    in_bcast,
    input  logic [LANES*WORD-1:0]   in_data,
    output logic                    out_valid,
    output logic [LANES*WORD-1:0]   out_data
);
    localparam int unsigned VEC_W = LANES * WORD;

    typedef struct packed {
        logic             rdy;
        logic             s1_vld;
        cvt_ctl_t         s1_ctl;
        logic [VEC_W-1:0] s1_data;
        logic             s2_vld;
        logic [VEC_W-1:0] s2_data;
    } pipe_t;

    pipe_t       st_d;
    pipe_t       st_q;
    logic [31:0] lane_y [LANES];
    logic        fire;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cvt_lane u_lane (
            .a      (st_q.s1_data[g*WORD +: WORD]),
            .to_int (st_q.s1_ctl.f2i),
            .sgn    (st_q.s1_ctl.sgn),
            .y      (lane_y[g])
        );
    end

    always_comb begin
        fire         = in_valid && st_q.rdy;
        st_d         = st_q;
        st_d.rdy     = 1'b1;
        st_d.s1_vld  = fire;
        if (fire) begin
            st_d.s1_ctl  = '{f2i: in_f2i, sgn: in_signed, bcast: in_bcast};
            st_d.s1_data = in_data;
        end
        st_d.s2_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            for (int i = 0; i < LANES; i++) begin
                st_d.s2_data[i*WORD +: WORD] = st_q.s1_ctl.bcast ? lane_y[0] : lane_y[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = st_q.rdy;
    assign out_valid = st_q.s2_vld;
    assign out_data  = st_q.s2_data;
endmodule

// File: rtl/cvt_unit_chk.sv
module cvt_unit_chk #(
    parameter int unsigned LANES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  in_f2i,
    input logic                  in_signed,
    input logic                  in_bcast,
    input logic [LANES*32-1:0]   in_data,
    input logic                  out_valid,
    input logic [LANES*32-1:0]   out_data
);
    logic take;
    logic nan0;
    assign take = in_valid && in_ready;
    assign nan0 = in_data[30:0] > 31'h7F80_0000;

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(take, 2));

    // R7
    bcast_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(take && in_bcast, 2)) |->
        (out_data[LANES*32-1:32] == {(LANES-1){out_data[31:0]}}));

    // R3
    nan_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && in_f2i && in_signed && nan0, 2) |->
        (out_data[31:0] == ($past(in_data[31], 2) ? 32'h8000_0000 : 32'h7FFF_FFFF)));

    // R4
    nan_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && in_f2i && !in_signed && nan0, 2) |->
        (out_data[31:0] == ($past(in_data[31], 2) ? 32'h0000_0000 : 32'hFFFF_FFFF)));

    // R2
    neg_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && in_f2i && !in_signed && in_data[31] && !nan0, 2) |->
        (out_data[31:0] == 32'd0));

    // R5
    zero_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take && !in_f2i && (in_data[31:0] == 32'd0), 2) |->
        (out_data[31:0] == 32'd0));

    // R9
    ready_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_ready) |-> in_ready);
endmodule

bind cvt_unit cvt_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_f2i    (in_f2i),
    .in_signed (in_signed),
    .in_bcast  (in_bcast),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_cvt_unit.sv
module tb_cvt_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_f2i = 1'b0;
    logic         in_signed = 1'b0;
    logic         in_bcast = 1'b0;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [127:0] exp_q [$];
    int           cyc_q [$];
    string        tag_q [$];

    cvt_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_f2i(in_f2i), .in_signed(in_signed), .in_bcast(in_bcast),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // driver: one request per cycle, expected result queued
    task automatic send(input logic f2i, input logic sgn, input logic bc,
                        input logic [127:0] din, input logic [127:0] expv, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_f2i    = f2i;
        in_signed = sgn;
        in_bcast  = bc;
        in_data   = din;
        exp_q.push_back(expv);
        cyc_q.push_back(cyc + 2);
        tag_q.push_back(tag);
    endtask

    task automatic scal(input logic f2i, input logic sgn, input logic [31:0] a,
                        input logic [31:0] e, input string tag);
        send(f2i, sgn, 1'b1, {32'h3F80_0000, 32'hDEAD_BEEF, 32'h7FC0_0000, a}, {4{e}}, tag);
    endtask

    // monitor: scoreboard compare
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 actual=unexpected output %h expected=no output", out_data);
            end else begin
                automatic logic [127:0] e = exp_q.pop_front();
                automatic int           c = cyc_q.pop_front();
                automatic string        t = tag_q.pop_front();
                chk(t, out_data, e);
                checks++;
                if (cyc != c) begin
                    errors++;
                    $display("FAIL R10 actual=cycle %0d expected=cycle %0d", cyc, c);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: request presented during reset must be ignored
        in_valid = 1'b1; in_f2i = 1'b1; in_signed = 1'b1; in_bcast = 1'b1;
        in_data  = {4{32'h3F80_0000}};
        repeat (5) @(negedge clk);
        chk("R9 ready in reset", {127'd0, in_ready}, 128'd0);
        chk("R9 out_valid in reset", {127'd0, out_valid}, 128'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 ready after reset", {127'd0, in_ready}, 128'd1);

        // R1 signed float to int
        scal(1, 1, 32'h3FC0_0000, 32'h0000_0001, "R1 1.5");
        scal(1, 1, 32'hBFC0_0000, 32'hFFFF_FFFF, "R1 -1.5");
        scal(1, 1, 32'h3F00_0000, 32'h0000_0000, "R1 0.5");
        scal(1, 1, 32'h47C3_5000, 32'h0001_86A0, "R1 100000");
        scal(1, 1, 32'h4F00_0000, 32'h7FFF_FFFF, "R1 2^31 clamp");
        scal(1, 1, 32'hCF00_0000, 32'h8000_0000, "R1 -2^31 exact");
        scal(1, 1, 32'h7F80_0000, 32'h7FFF_FFFF, "R1 +inf");
        scal(1, 1, 32'hFF80_0000, 32'h8000_0000, "R1 -inf");
        // R3 signed NaN
        scal(1, 1, 32'h7FC0_0000, 32'h7FFF_FFFF, "R3 +NaN");
        scal(1, 1, 32'hFFC0_0000, 32'h8000_0000, "R3 -NaN");
        scal(1, 1, 32'h7F80_0001, 32'h7FFF_FFFF, "R3 +NaN min payload");
        // R2 unsigned float to int
        scal(1, 0, 32'hBF80_0000, 32'h0000_0000, "R2 -1");
        scal(1, 0, 32'h4F00_0000, 32'h8000_0000, "R2 2^31");
        scal(1, 0, 32'h4F7F_FFFF, 32'hFFFF_FF00, "R2 below 2^32");
        scal(1, 0, 32'h4F80_0000, 32'hFFFF_FFFF, "R2 2^32 clamp");
        scal(1, 0, 32'h7F80_0000, 32'hFFFF_FFFF, "R2 +inf");
        scal(1, 0, 32'hFF80_0000, 32'h0000_0000, "R2 -inf");
        // R4 unsigned NaN
        scal(1, 0, 32'h7FC0_0000, 32'hFFFF_FFFF, "R4 +NaN");
        scal(1, 0, 32'hFFC0_0000, 32'h0000_0000, "R4 -NaN");
        // R5 signed int to float
        scal(0, 1, 32'h0000_0000, 32'h0000_0000, "R5 zero");
        scal(0, 1, 32'h0000_0001, 32'h3F80_0000, "R5 one");
        scal(0, 1, 32'hFFFF_FFFF, 32'hBF80_0000, "R5 minus one");
        scal(0, 1, 32'h8000_0000, 32'hCF00_0000, "R5 most negative");
        scal(0, 1, 32'h7FFF_FFFF, 32'h4F00_0000, "R5 round to 2^31");
        scal(0, 1, 32'h0100_0001, 32'h4B80_0000, "R5 tie even down");
        scal(0, 1, 32'h0100_0003, 32'h4B80_0002, "R5 tie even up");
        // R6 unsigned int to float
        scal(0, 0, 32'hFFFF_FFFF, 32'h4F80_0000, "R6 all ones");
        scal(0, 0, 32'h8000_0000, 32'h4F00_0000, "R6 2^31");
        // R7 broadcast with differing upper lanes
        send(1, 1, 1, {32'hFFC0_0000, 32'hBF80_0000, 32'h4F80_0000, 32'h47C3_5000},
             {4{32'h0001_86A0}}, "R7 broadcast lane0");
        // R8 four-wide
        send(1, 1, 0, {32'hFF80_0000, 32'h7FC0_0000, 32'hBFC0_0000, 32'h3FC0_0000},
             {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001}, "R8 f2i four-wide");
        send(0, 0, 0, {32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0003, 32'h0100_0001},
             {32'h4F80_0000, 32'h4F00_0000, 32'h4040_0000, 32'h4B80_0000}, "R8 R6 i2f four-wide");
        send(0, 1, 0, {32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0100_0003},
             {32'h0000_0000, 32'hBF80_0000, 32'hCF00_0000, 32'h4B80_0002}, "R8 R5 i2f four-wide");
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = {4{32'h7FC0_0000}};
        // R9 idle cycles: valid low, monitor flags any output beyond queue
        repeat (8) @(negedge clk);
        chk("R10 all results returned", 128'(exp_q.size()), 128'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule